// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block forms operand and branch addresses for a 16-bit processor that reaches a 20-bit memory through 16-bit segment values. For each strobed request it adds an optional displacement, base term and index term into a 16-bit offset. It picks the segment implied by the terms used and produces the physical address. For the auto-increment and auto-decrement modes it also returns the new value of the pointer register used.

The decoder drives a mode code, the operand-field selects, the displacement and the element size, together with current copies of the pointer, instruction-pointer and segment registers. One clock later the block returns a registered result with a matching valid flag. The register file applies any pointer write-back the block reports. The memory access itself happens elsewhere.

Top module: `seg_ea_gen`

## Requirements
- R1: While rst_ni is low every output is zero, including valid_o and ptr_we_o.
- R2: valid_o is high exactly in the cycle after a cycle with valid_i high. Results appear in that cycle. When valid_i is low, all data outputs keep their previous values.
- R3: With disp_wide_i = 1 the displacement is disp_i[15:0]. With disp_wide_i = 0 it is disp_i[7:0] sign-extended to 16 bits, and disp_i[15:8] has no effect.
- R4: Mode 0 (memory operand) gives offset = displacement + base term + index term, modulo 2^16. base_sel_i is decoded as 0 or 3 = none, 1 = BX, 2 = BP. index_sel_i is decoded as 0 or 3 = none, 1 = SI, 2 = DI.
- R5: Data accesses use the stack segment (seg_id_o = 1, seg_o = ss_i) when the base is BP, and the data segment (seg_id_o = 0, seg_o = ds_i) otherwise. In modes 1 and 2 the stack segment is used when the pointer is BP.
- R6: Mode 1 (post-increment) uses the selected pointer's current value as the offset. It reports ptr_we_o = 1, ptr_idx_o = ptr_sel_i and ptr_val_o = pointer + elem_size_i modulo 2^16. ptr_sel_i is decoded as 0 = BX, 1 = BP, 2 = SI, 3 = DI.
- R7: Mode 2 (pre-decrement) computes ptr_val_o = pointer − elem_size_i modulo 2^16, uses that decremented value as the offset, and reports ptr_we_o = 1 and ptr_idx_o = ptr_sel_i.
- R8: Mode 3 (near branch) gives offset = ip_i + displacement modulo 2^16, with seg_o = cs_i and seg_id_o = 2.
- R9: Mode 4 (far branch) gives offset = disp_i[15:0] whatever disp_wide_i is, with seg_o = far_cs_i and seg_id_o = 2.
- R10: phys_o = (seg_o · 16 + offset_o) modulo 2^20.
- R11: ptr_we_o is 0 for every mode except 1 and 2. Mode codes 5, 6 and 7 behave exactly like mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| mode_i | input | 3 | Addressing mode code |
| base_sel_i | input | 2 | Base term select (mode 0) |
| index_sel_i | input | 2 | Index term select (mode 0) |
| ptr_sel_i | input | 2 | Pointer select (modes 1, 2) |
| disp_i | input | 16 | Displacement or far target offset |
| disp_wide_i | input | 1 | 1 = 16-bit displacement, 0 = 8-bit |
| elem_size_i | input | 2 | Element size in bytes for pointer update |
| bx_i | input | 16 | BX value |
| bp_i | input | 16 | BP value |
| si_i | input | 16 | SI value |
| di_i | input | 16 | DI value |
| ip_i | input | 16 | Current instruction pointer |
| cs_i | input | 16 | Code segment |
| ds_i | input | 16 | Data segment |
| ss_i | input | 16 | Stack segment |
| far_cs_i | input | 16 | Code segment carried by a far branch |
| valid_o | output | 1 | Result valid |
| offset_o | output | 16 | Effective offset |
| seg_o | output | 16 | Selected segment value |
| seg_id_o | output | 2 | 0 data, 1 stack, 2 code |
| phys_o | output | 20 | Physical address |
| ptr_we_o | output | 1 | Pointer write-back request |
| ptr_idx_o | output | 2 | Pointer to update |
| ptr_val_o | output | 16 | New pointer value |

## Verification
The bench targets sign extension of a displacement byte with bit 7 set while the upper byte holds garbage. A design that zero-extends or uses the raw upper byte would point far from the intended operand. It targets the BP-with-index combination, where a design that keys segment choice on the index would pick the data segment. It also covers offset wrap at 0xFFFF and pointer wrap at zero under pre-decrement, where a carry leaking into bit 16 would shift the physical address by 64 KiB. Finally it checks that pre-decrement addresses the decremented value, and that a segment of 0xFFFF with a large offset folds the physical address back into 20 bits.

// File: rtl/seg_ea_pkg.sv
package seg_ea_pkg;
  typedef enum logic [2:0] {
    MODE_MEM     = 3'd0,
    MODE_POSTINC = 3'd1,
    MODE_PREDEC  = 3'd2,
    MODE_BR_NEAR = 3'd3,
    MODE_BR_FAR  = 3'd4
  } ea_mode_e;

  typedef enum logic [1:0] {
    SEG_DATA  = 2'd0,
    SEG_STACK = 2'd1,
    SEG_CODE  = 2'd2
  } seg_id_e;

  localparam logic [1:0] BASE_BX = 2'd1;
  localparam logic [1:0] BASE_BP = 2'd2;
  localparam logic [1:0] IDX_SI  = 2'd1;
  localparam logic [1:0] IDX_DI  = 2'd2;
  localparam logic [1:0] PTR_BX  = 2'd0;
  localparam logic [1:0] PTR_BP  = 2'd1;
  localparam logic [1:0] PTR_SI  = 2'd2;
  localparam logic [1:0] PTR_DI  = 2'd3;
endpackage

// File: rtl/seg_ea_disp.sv
module seg_ea_disp #(
  parameter int unsigned W        = 16,
  parameter int unsigned NARROW_W = 8
) (
  input  logic [W-1:0] disp_i,
  input  logic         wide_i,
  output logic [W-1:0] disp_o
);
  generate
    if (NARROW_W >= W) begin : g_full
      logic unused_wide;
      assign unused_wide = wide_i;
      assign disp_o = disp_i;
    end else begin : g_ext
      logic [W-1:0] narrow_ext;
      assign narrow_ext = {{(W-NARROW_W){disp_i[NARROW_W-1]}}, disp_i[NARROW_W-1:0]};
      assign disp_o = wide_i ? disp_i : narrow_ext;
    end
  endgenerate
endmodule

// File: rtl/seg_ea_calc.sv
module seg_ea_calc
  import seg_ea_pkg::*;
#(
  parameter int unsigned W      = 16,
  parameter int unsigned SIZE_W = 2
) (
  input  logic [2:0]        mode_i,
  input  logic [1:0]        base_sel_i,
  input  logic [1:0]        index_sel_i,
  input  logic [1:0]        ptr_sel_i,
  input  logic [W-1:0]      disp_ext_i,
  input  logic [W-1:0]      disp_raw_i,
  input  logic [SIZE_W-1:0] elem_size_i,
  input  logic [W-1:0]      bx_i,
  input  logic [W-1:0]      bp_i,
  input  logic [W-1:0]      si_i,
  input  logic [W-1:0]      di_i,
  input  logic [W-1:0]      ip_i,
  input  logic [W-1:0]      cs_i,
  input  logic [W-1:0]      ds_i,
  input  logic [W-1:0]      ss_i,
  input  logic [W-1:0]      far_cs_i,
  output logic [W-1:0]      offset_o,
  output logic [W-1:0]      seg_o,
  output logic [1:0]        seg_id_o,
  output logic              ptr_we_o,
  output logic [1:0]        ptr_idx_o,
  output logic [W-1:0]      ptr_val_o
);
  logic [W-1:0] base_term, index_term, ptr_cur, step, ptr_inc, ptr_dec;
  seg_id_e      seg_sel;
  ea_mode_e     mode;

  assign mode    = ea_mode_e'(mode_i);
  assign step    = {{(W-SIZE_W){1'b0}}, elem_size_i};
  assign ptr_inc = ptr_cur + step;
  assign ptr_dec = ptr_cur - step;

  always_comb begin
    unique case (base_sel_i)
      BASE_BX: base_term = bx_i;
      BASE_BP: base_term = bp_i;
      default: base_term = '0;
    endcase
    unique case (index_sel_i)
      IDX_SI:  index_term = si_i;
      IDX_DI:  index_term = di_i;
      default: index_term = '0;
    endcase
    unique case (ptr_sel_i)
      PTR_BX:  ptr_cur = bx_i;
      PTR_BP:  ptr_cur = bp_i;
      PTR_SI:  ptr_cur = si_i;
      default: ptr_cur = di_i;
    endcase
  end

  always_comb begin
    ptr_we_o  = 1'b0;
    ptr_idx_o = ptr_sel_i;
    ptr_val_o = ptr_cur;
    case (mode)
      MODE_POSTINC: begin
        offset_o  = ptr_cur;
        ptr_val_o = ptr_inc;
        ptr_we_o  = 1'b1;
        seg_sel   = (ptr_sel_i == PTR_BP) ? SEG_STACK : SEG_DATA;
      end
      MODE_PREDEC: begin
        offset_o  = ptr_dec;  // access follows the update
        ptr_val_o = ptr_dec;
        ptr_we_o  = 1'b1;
        seg_sel   = (ptr_sel_i == PTR_BP) ? SEG_STACK : SEG_DATA;
      end
      MODE_BR_NEAR: begin
        offset_o = ip_i + disp_ext_i;
        seg_sel  = SEG_CODE;
      end
      MODE_BR_FAR: begin
        offset_o = disp_raw_i;
        seg_sel  = SEG_CODE;
      end
      default: begin
        offset_o = disp_ext_i + base_term + index_term;
        seg_sel  = (base_sel_i == BASE_BP) ? SEG_STACK : SEG_DATA;
      end
    endcase
  end

  always_comb begin
    unique case (seg_sel)
      SEG_STACK: seg_o = ss_i;
      SEG_CODE:  seg_o = (mode == MODE_BR_FAR) ? far_cs_i : cs_i;
      default:   seg_o = ds_i;
    endcase
  end
  assign seg_id_o = seg_sel;
endmodule

// File: rtl/seg_ea_phys.sv
module seg_ea_phys #(
  parameter int unsigned W     = 16,
  parameter int unsigned SHIFT = 4,
  parameter int unsigned PW    = 20
) (
  input  logic [W-1:0]  seg_i,
  input  logic [W-1:0]  offset_i,
  output logic [PW-1:0] phys_o
);
  localparam int unsigned SEG_SH_W = W + SHIFT;
  logic [SEG_SH_W-1:0] seg_full;
  logic [PW-1:0]       seg_sh, ofs_ext;
  assign seg_full = {seg_i, {SHIFT{1'b0}}};
  assign seg_sh   = PW'(seg_full);
  assign ofs_ext  = PW'(offset_i);
  assign phys_o   = seg_sh + ofs_ext;
endmodule

// File: rtl/seg_ea_gen.sv
module seg_ea_gen #(
  parameter int unsigned W        = 16,
  parameter int unsigned NARROW_W = 8,
  parameter int unsigned SIZE_W   = 2,
  parameter int unsigned SHIFT    = 4,
  parameter int unsigned PW       = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        mode_i,
  input  logic [1:0]        base_sel_i,
  input  logic [1:0]        index_sel_i,
  input  logic [1:0]        ptr_sel_i,
  input  logic [W-1:0]      disp_i,
  input  logic              disp_wide_i,
  input  logic [SIZE_W-1:0] elem_size_i,
  input  logic [W-1:0]      bx_i,
  input  logic [W-1:0]      bp_i,
  input  logic [W-1:0]      si_i,
  input  logic [W-1:0]      di_i,
  input  logic [W-1:0]      ip_i,
  input  logic [W-1:0]      cs_i,
  input  logic [W-1:0]      ds_i,
  input  logic [W-1:0]      ss_i,
  input  logic [W-1:0]      far_cs_i,
  output logic              valid_o,
  output logic [W-1:0]      offset_o,
  output logic [W-1:0]      seg_o,
  output logic [1:0]        seg_id_o,
  output logic [PW-1:0]     phys_o,
  output logic              ptr_we_o,
  output logic [1:0]        ptr_idx_o,
  output logic [W-1:0]      ptr_val_o
);
  logic [W-1:0]  disp_ext, ofs_c, seg_c, pval_c;
  logic [1:0]    sid_c, pidx_c;
  logic          pwe_c;
  logic [PW-1:0] phys_c;

  seg_ea_disp #(.W(W), .NARROW_W(NARROW_W)) u_disp (
    .disp_i (disp_i),
    .wide_i (disp_wide_i),
    .disp_o (disp_ext)
  );

  seg_ea_calc #(.W(W), .SIZE_W(SIZE_W)) u_calc (
    .mode_i      (mode_i),
    .base_sel_i  (base_sel_i),
    .index_sel_i (index_sel_i),
    .ptr_sel_i   (ptr_sel_i),
    .disp_ext_i  (disp_ext),
    .disp_raw_i  (disp_i),
    .elem_size_i (elem_size_i),
    .bx_i        (bx_i),
    .bp_i        (bp_i),
    .si_i        (si_i),
    .di_i        (di_i),
    .ip_i        (ip_i),
    .cs_i        (cs_i),
    .ds_i        (ds_i),
    .ss_i        (ss_i),
    .far_cs_i    (far_cs_i),
    .offset_o    (ofs_c),
    .seg_o       (seg_c),
    .seg_id_o    (sid_c),
    .ptr_we_o    (pwe_c),
    .ptr_idx_o   (pidx_c),
    .ptr_val_o   (pval_c)
  );

  seg_ea_phys #(.W(W), .SHIFT(SHIFT), .PW(PW)) u_phys (
    .seg_i    (seg_c),
    .offset_i (ofs_c),
    .phys_o   (phys_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
    end
  end

  // data registers load only on a strobe and hold otherwise
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      offset_o  <= '0;
      seg_o     <= '0;
      seg_id_o  <= '0;
      phys_o    <= '0;
      ptr_we_o  <= 1'b0;
      ptr_idx_o <= '0;
      ptr_val_o <= '0;
    end else if (valid_i) begin
      offset_o  <= ofs_c;
      seg_o     <= seg_c;
      seg_id_o  <= sid_c;
      phys_o    <= phys_c;
      ptr_we_o  <= pwe_c;
      ptr_idx_o <= pidx_c;
      ptr_val_o <= pval_c;
    end
  end
endmodule

// File: rtl/seg_ea_chk.sv
module seg_ea_chk #(
  parameter int unsigned W      = 16,
  parameter int unsigned SIZE_W = 2,
  parameter int unsigned SHIFT  = 4,
  parameter int unsigned PW     = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [2:0]        mode_i,
  input logic [SIZE_W-1:0] elem_size_i,
  input logic              valid_o,
  input logic [W-1:0]      offset_o,
  input logic [W-1:0]      seg_o,
  input logic [1:0]        seg_id_o,
  input logic [PW-1:0]     phys_o,
  input logic              ptr_we_o,
  input logic [W-1:0]      ptr_val_o
);
  logic [W+SHIFT-1:0] seg_full;
  logic [PW-1:0]      phys_exp;
  assign seg_full = {seg_o, {SHIFT{1'b0}}};
  assign phys_exp = PW'(seg_full) + PW'(offset_o);

  AST_VALID_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o) else $error("valid lost");  // R2
  AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(offset_o) && $stable(phys_o))) else $error("hold broken");  // R2
  AST_PHYS_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> phys_o == phys_exp) else $error("phys sum");  // R10
  AST_POSTINC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 3'd1) |=> (ptr_we_o && ptr_val_o == offset_o + W'($past(elem_size_i)))) else $error("postinc");  // R6
  AST_PREDEC_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 3'd2) |=> (ptr_we_o && ptr_val_o == offset_o)) else $error("predec");  // R7
  AST_NO_WRITEBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i != 3'd1 && mode_i != 3'd2) |=> !ptr_we_o) else $error("stray write-back");  // R11
  AST_BRANCH_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (mode_i == 3'd3 || mode_i == 3'd4)) |=> seg_id_o == 2'd2) else $error("branch seg");  // R8
  AST_RESET_IDLE: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && !ptr_we_o && phys_o == '0)) else $error("reset state");  // R1
endmodule

bind seg_ea_gen seg_ea_chk #(.W(W), .SIZE_W(SIZE_W), .SHIFT(SHIFT), .PW(PW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .mode_i      (mode_i),
  .elem_size_i (elem_size_i),
  .valid_o     (valid_o),
  .offset_o    (offset_o),
  .seg_o       (seg_o),
  .seg_id_o    (seg_id_o),
  .phys_o      (phys_o),
  .ptr_we_o    (ptr_we_o),
  .ptr_val_o   (ptr_val_o)
);

// File: tb/seg_ea_gen_bench.sv
`timescale 1ns/1ps
module seg_ea_gen_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_ni, valid_i, disp_wide_i;
  logic [2:0]  mode_i;
  logic [1:0]  base_sel_i, index_sel_i, ptr_sel_i, elem_size_i;
  logic [15:0] disp_i, bx_i, bp_i, si_i, di_i, ip_i, cs_i, ds_i, ss_i, far_cs_i;
  logic        valid_o, ptr_we_o;
  logic [15:0] offset_o, seg_o, ptr_val_o;
  logic [1:0]  seg_id_o, ptr_idx_o;
  logic [19:0] phys_o;

  seg_ea_gen u_seg_ea_gen (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .mode_i(mode_i),
    .base_sel_i(base_sel_i), .index_sel_i(index_sel_i), .ptr_sel_i(ptr_sel_i),
    .disp_i(disp_i), .disp_wide_i(disp_wide_i), .elem_size_i(elem_size_i),
    .bx_i(bx_i), .bp_i(bp_i), .si_i(si_i), .di_i(di_i), .ip_i(ip_i),
    .cs_i(cs_i), .ds_i(ds_i), .ss_i(ss_i), .far_cs_i(far_cs_i),
    .valid_o(valid_o), .offset_o(offset_o), .seg_o(seg_o), .seg_id_o(seg_id_o),
    .phys_o(phys_o), .ptr_we_o(ptr_we_o), .ptr_idx_o(ptr_idx_o), .ptr_val_o(ptr_val_o)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  int e_valid = 0, e_ofs = 0, e_seg = 0, e_id = 0, e_phys = 0, e_we = 0, e_idx = 0, e_val = 0;
  string t_ofs = "R4", t_seg = "R5";

  task automatic chk(string tag, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  function automatic int pick_reg(int code, int k);
    // k: 0 base select, 1 index select, 2 pointer select
    if (k == 0) return (code == 1) ? int'(bx_i) : (code == 2) ? int'(bp_i) : 0;
    if (k == 1) return (code == 1) ? int'(si_i) : (code == 2) ? int'(di_i) : 0;
    case (code)
      0: return int'(bx_i);
      1: return int'(bp_i);
      2: return int'(si_i);
      default: return int'(di_i);
    endcase
  endfunction

  task automatic model();
    int d, p, m;
    if (!valid_i) begin e_valid = 0; return; end
    e_valid = 1;
    m = int'(mode_i);
    d = disp_wide_i ? int'(disp_i) : ((int'(disp_i[7:0]) ^ 128) - 128);
    p = pick_reg(int'(ptr_sel_i), 2);
    e_we = 0; e_idx = int'(ptr_sel_i);
    if (m == 1) begin
      e_ofs = p; e_val = (p + int'(elem_size_i)) & 16'hFFFF; e_we = 1;
      e_id = (ptr_sel_i == 1) ? 1 : 0; t_ofs = "R6"; t_seg = "R5";
    end else if (m == 2) begin
      e_val = (p - int'(elem_size_i)) & 16'hFFFF; e_ofs = e_val; e_we = 1;
      e_id = (ptr_sel_i == 1) ? 1 : 0; t_ofs = "R7"; t_seg = "R5";
    end else if (m == 3) begin
      e_ofs = (int'(ip_i) + d) & 16'hFFFF; e_id = 2; t_ofs = "R8"; t_seg = "R8";
    end else if (m == 4) begin
      e_ofs = int'(disp_i); e_id = 2; t_ofs = "R9"; t_seg = "R9";
    end else begin
      e_ofs = (d + pick_reg(int'(base_sel_i), 0) + pick_reg(int'(index_sel_i), 1)) & 16'hFFFF;
      e_id = (base_sel_i == 2) ? 1 : 0;
      t_ofs = (m >= 5) ? "R11" : (disp_wide_i ? "R4" : "R3"); t_seg = "R5";
    end
    e_seg = (e_id == 1) ? int'(ss_i) : (e_id == 0) ? int'(ds_i) : (m == 4) ? int'(far_cs_i) : int'(cs_i);
    e_phys = ((e_seg << 4) + e_ofs) & 20'hFFFFF;
  endtask

  task automatic compare();
    chk("R2 valid", int'(valid_o), e_valid);
    chk(t_ofs, int'(offset_o), e_ofs);
    chk(t_seg, int'(seg_o), e_seg);
    chk(t_seg, int'(seg_id_o), e_id);
    chk("R10 phys", int'(phys_o), e_phys);
    chk("R11 we", int'(ptr_we_o), e_we);
    if (e_we != 0) begin
      chk(t_ofs, int'(ptr_idx_o), e_idx);
      chk(t_ofs, int'(ptr_val_o), e_val);
    end
  endtask

  task automatic step();
    model();
    @(negedge clk);
    compare();
  endtask

  task automatic req(input logic [2:0] m, input logic [1:0] b, input logic [1:0] x,
                     input logic [1:0] p, input logic [15:0] d, input logic w, input logic [1:0] s);
    valid_i = 1; mode_i = m; base_sel_i = b; index_sel_i = x; ptr_sel_i = p;
    disp_i = d; disp_wide_i = w; elem_size_i = s;
    step();
  endtask

  task automatic idle();
    valid_i = 0; disp_i = ~disp_i; mode_i = mode_i + 3'd1;
    step();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    rst_ni = 0; valid_i = 0; mode_i = 0; base_sel_i = 0; index_sel_i = 0; ptr_sel_i = 0;
    disp_i = 0; disp_wide_i = 0; elem_size_i = 0;
    bx_i = 16'h1000; bp_i = 16'h2000; si_i = 16'h0030; di_i = 16'h0040; ip_i = 16'h0100;
    cs_i = 16'hC000; ds_i = 16'hD000; ss_i = 16'h5000; far_cs_i = 16'hF000;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 valid", int'(valid_o), 0);
    chk("R1 offset", int'(offset_o), 0);
    chk("R1 phys", int'(phys_o), 0);
    chk("R1 we", int'(ptr_we_o), 0);
    chk("R1 seg", int'(seg_o), 0);
    rst_ni = 1;
    @(negedge clk);

    req(3'd0, 2'd0, 2'd0, 2'd0, 16'h1234, 1, 2'd1);   // R4 direct
    req(3'd0, 2'd1, 2'd0, 2'd0, 16'h0000, 1, 2'd1);   // R4 register indirect BX
    req(3'd0, 2'd1, 2'd1, 2'd0, 16'h0010, 1, 2'd1);   // R4 BX+SI+disp
    req(3'd0, 2'd2, 2'd2, 2'd0, 16'h0004, 1, 2'd1);   // R5 BP+DI -> stack
    req(3'd0, 2'd0, 2'd1, 2'd0, 16'h0000, 1, 2'd1);   // R5 SI only -> data
    req(3'd0, 2'd3, 2'd3, 2'd0, 16'hAB80, 0, 2'd1);   // R3 0x80 -> -128, upper ignored
    req(3'd0, 2'd1, 2'd0, 2'd0, 16'h557F, 0, 2'd1);   // R3 positive narrow
    bx_i = 16'hFFFF;
    req(3'd0, 2'd1, 2'd0, 2'd0, 16'h0002, 1, 2'd1);   // R4 wrap
    idle(); idle();                                   // R2 hold
    req(3'd1, 2'd0, 2'd0, 2'd2, 16'h0000, 1, 2'd2);   // R6 SI post-inc
    req(3'd1, 2'd0, 2'd0, 2'd1, 16'h0000, 1, 2'd1);   // R6 BP -> stack
    di_i = 16'h0000;
    req(3'd2, 2'd0, 2'd0, 2'd3, 16'h0000, 1, 2'd2);   // R7 pre-dec wrap
    req(3'd2, 2'd0, 2'd0, 2'd0, 16'h0000, 1, 2'd1);   // R7 BX
    req(3'd3, 2'd0, 2'd0, 2'd0, 16'h00F0, 0, 2'd1);   // R8 near back
    req(3'd3, 2'd0, 2'd0, 2'd0, 16'h0200, 1, 2'd1);   // R8 near wide
    req(3'd4, 2'd0, 2'd0, 2'd0, 16'hBEEF, 0, 2'd1);   // R9 far, narrow flag ignored
    req(3'd6, 2'd2, 2'd1, 2'd0, 16'h0008, 1, 2'd1);   // R11 reserved as mode 0
    ds_i = 16'hFFFF;
    req(3'd0, 2'd0, 2'd0, 2'd0, 16'hFFFF, 1, 2'd1);   // R10 phys wrap
    idle();

    for (int i = 0; i < 500; i++) begin
      bx_i = 16'($urandom); bp_i = 16'($urandom); si_i = 16'($urandom); di_i = 16'($urandom);
      ip_i = 16'($urandom); cs_i = 16'($urandom); ds_i = 16'($urandom); ss_i = 16'($urandom);
      far_cs_i = 16'($urandom);
      if ($urandom_range(0, 3) == 0) idle();
      else req(3'($urandom_range(0, 7)), 2'($urandom), 2'($urandom), 2'($urandom),
               16'($urandom), 1'($urandom), 2'($urandom));
    end
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R2 watchdog got hang exp finish");
      summary();
      $finish;
    end
  end
endmodule